// File: doc/BRIEF.md
# Four-Line Transmit Scanner Controller

This block is the transmit half of a small serial multiplexer. Four serial lines share one transmit data register. Software chooses which lines may transmit by setting bits in a transmit-control register. A scanner walks the lines in round-robin order and stops on the first line that is both enabled and idle. It then raises a ready flag, reports the line number in the control/status register, and can request an interrupt. Software answers with one write to the data register. That character goes to the reported line's serializer, and the scanner moves on to the next line.

Because there is only one data register, software steers the scanner by masking lines. When the scanner offers a line that software does not want, software clears that line's enable bit. The scanner then drops the line and looks further. A master clear empties the block in a fixed number of cycles. A single active-low DTR output is controlled by one bit in the upper byte of the transmit-control register.

All access goes through a plain word-addressed register port. A write takes effect on the clock edge where `reg_wr` is high, and reads are combinational. The port has no back-pressure. A data write made while no line is ready is dropped, so software must see the ready flag before it writes. The serial outputs are free-running, with no handshake.

Top module: `txs_mux`

## Requirements
- R1: After reset every register reads 0, `tx_irq` is 0, every `ser_out` bit is 1 (idle) and `dtr_n` is 1.
- R2: The transmit-control register (address 1) keeps a line-enable bit for line n at bit n (bits 3:0) and the DTR bit at bit 10. Every other bit reads 0. A line whose enable bit is 0 counts as empty and is never offered.
- R3: The control/status register (address 0) has clear at bit 4, scan enable at bit 5, interrupt enable at bit 14 and ready at bit 15, with the offered line number in bits 9:8. Ready can be set only while scan enable is 1.
- R4: Lines are offered in round-robin order, starting from the line after the one last served. After a clear, the search starts from line 0.
- R5: A write to address 2 while ready is set sends data bits 7:0 on the offered line as one frame. The frame is a 0 start bit, 8 data bits LSB first, then a 1 stop bit, each bit lasting CYCLES_PER_BIT cycles (4 by default). Ready reads 0 in the cycle after the write.
- R6: A write to address 2 while ready is 0 is ignored. No line starts a frame.
- R7: A line is not offered again while its serializer is still sending a frame.
- R8: If the offered line's enable bit is cleared, the scanner drops that line and offers the next enabled line.
- R9: `tx_irq` is 1 exactly when ready and interrupt enable are both 1.
- R10: Writing 1 to bit 4 of address 0 starts a master clear. Bit 4 reads 1 for the next 16 cycles and then 0. The clear zeroes the enables, the DTR bit, scan enable, interrupt enable and ready, and it aborts frames in progress.
- R11: `dtr_n` is the inverse of bit 10 of the transmit-control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Word address: 0 control/status, 1 transmit control, 2 transmit data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| tx_irq | output | 1 | Transmit interrupt request |
| ser_out | output | 4 | Serial outputs, one per line, idle high |
| dtr_n | output | 1 | Active-low DTR output |

## Verification
A wrong scan pointer shows at the next poll of the control/status register, as a line number outside the round-robin order. A wrong load decode shows within one frame time (40 cycles), as a character on the wrong serial pin or a missing frame. A ready flag that fails to drop appears in the cycle right after an accepting write. A mis-timed clear counter appears as the clear bit reading 1 one cycle too long or too short. The bench sweeps every non-empty enable mask and decodes every serial line independently, so each of these faults reaches a counted check.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int CLR_BIT  = 4;
  localparam int SCAN_BIT = 5;
  localparam int LINE_LSB = 8;
  localparam int DTR_BIT  = 10;
  localparam int TIE_BIT  = 14;
  localparam int RDY_BIT  = 15;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_TCTL  = 2'd1,
    A_TDATA = 2'd2,
    A_SPARE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/txs_serializer.sv
module txs_serializer #(
  parameter int CHAR_BITS      = 8,
  parameter int CYCLES_PER_BIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 load,
  input  logic [CHAR_BITS-1:0] data,
  output logic                 busy,
  output logic                 sout
);
  localparam int FRAME  = CHAR_BITS + 2;
  localparam int CNT_W  = $clog2(FRAME + 1);
  localparam int TICK_W = (CYCLES_PER_BIT > 1) ? $clog2(CYCLES_PER_BIT) : 1;

  logic [FRAME-1:0]  sh;
  logic [CNT_W-1:0]  left;
  logic [TICK_W-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      tick <= '0;
    end else if (clr) begin
      sh   <= '1;
      left <= '0;
      tick <= '0;
    end else if (load) begin
      sh   <= {1'b1, data, 1'b0};
      left <= CNT_W'(FRAME);
      tick <= '0;
    end else if (left != '0) begin
      if (tick == TICK_W'(CYCLES_PER_BIT - 1)) begin
        tick <= '0;
        sh   <= {1'b1, sh[FRAME-1:1]};
        left <= left - 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  assign busy = (left != '0);
  assign sout = busy ? sh[0] : 1'b1;

  // R7: the scanner never hands a busy serializer a second character
  a_r7_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  // R5: an accepted character starts with a low start bit
  a_r5_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (busy && !sout));
endmodule

// File: rtl/txs_scanner.sv
module txs_scanner #(
  parameter int NUM_LINES = 4,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 scan_en,
  input  logic [NUM_LINES-1:0] en,
  input  logic [NUM_LINES-1:0] busy,
  input  logic                 load,
  output logic                 ready,
  output logic [LW-1:0]        cur_line
);
  logic [LW-1:0] ptr;

  function automatic logic [LW-1:0] nxt(input logic [LW-1:0] l);
    return (l == LW'(NUM_LINES - 1)) ? '0 : l + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready    <= 1'b0;
      ptr      <= '0;
      cur_line <= '0;
    end else if (clr) begin
      ready    <= 1'b0;
      ptr      <= '0;
      cur_line <= '0;
    end else if (ready) begin
      if (load || !scan_en || !en[cur_line]) begin
        ready <= 1'b0;
        ptr   <= nxt(cur_line);
      end
    end else if (scan_en) begin
      if (en[ptr] && !busy[ptr]) begin
        ready    <= 1'b1;
        cur_line <= ptr;
      end else begin
        ptr <= nxt(ptr);
      end
    end
  end

  // R7: a freshly offered line has an idle serializer
  a_r7_offer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !busy[cur_line]);
  // R5: an accepting write drops ready in the next cycle
  a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && load) |=> !ready);
  // R3: with scanning off, ready cannot appear
  a_r3_scan_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !ready) |=> !ready);
  // R8: a masked offered line is dropped
  a_r8_drop_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !en[cur_line]) |=> !ready);
endmodule

// File: rtl/txs_regs.sv
module txs_regs
  import txs_pkg::*;
#(
  parameter int NUM_LINES    = 4,
  parameter int CHAR_BITS    = 8,
  parameter int CLEAR_CYCLES = 16,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           addr,
  input  logic                 wr,
  input  logic [15:0]          wdata,
  output logic [15:0]          rdata,
  input  logic                 ready,
  input  logic [LW-1:0]        cur_line,
  output logic                 clr,
  output logic                 scan_en,
  output logic                 tie,
  output logic [NUM_LINES-1:0] en,
  output logic                 dtr_bit,
  output logic                 data_wr,
  output logic [CHAR_BITS-1:0] tx_char
);
  localparam int CW = $clog2(CLEAR_CYCLES + 1);

  logic [CW-1:0] clr_cnt;
  reg_addr_e     a;

  assign a   = reg_addr_e'(addr);
  assign clr = (clr_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_cnt <= '0;
      scan_en <= 1'b0;
      tie     <= 1'b0;
      en      <= '0;
      dtr_bit <= 1'b0;
    end else if (clr) begin
      clr_cnt <= clr_cnt - 1'b1;
      scan_en <= 1'b0;
      tie     <= 1'b0;
      en      <= '0;
      dtr_bit <= 1'b0;
    end else if (wr) begin
      case (a)
        A_CTRL: begin
          if (wdata[CLR_BIT]) begin
            clr_cnt <= CW'(CLEAR_CYCLES);
          end else begin
            scan_en <= wdata[SCAN_BIT];
            tie     <= wdata[TIE_BIT];
          end
        end
        A_TCTL: begin
          en      <= wdata[NUM_LINES-1:0];
          dtr_bit <= wdata[DTR_BIT];
        end
        default: ;
      endcase
    end
  end

  assign data_wr = wr && (a == A_TDATA) && !clr;
  assign tx_char = wdata[CHAR_BITS-1:0];

  always_comb begin
    rdata = '0;
    case (a)
      A_CTRL: begin
        rdata[CLR_BIT]           = clr;
        rdata[SCAN_BIT]          = scan_en;
        rdata[TIE_BIT]           = tie;
        rdata[RDY_BIT]           = ready;
        rdata[LINE_LSB +: LW]    = cur_line;
      end
      A_TCTL: begin
        rdata[NUM_LINES-1:0] = en;
        rdata[DTR_BIT]       = dtr_bit;
      end
      default: ;
    endcase
  end

  // R10: while clearing, every control bit settles to zero
  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (en == '0 && !tie && !scan_en && !dtr_bit));
  // R10: a clear in progress runs to its end without restarting
  a_r10_clear_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && $past(clr)) |-> (clr_cnt < $past(clr_cnt)));
endmodule

// File: rtl/txs_mux.sv
module txs_mux
  import txs_pkg::*;
#(
  parameter int NUM_LINES      = 4,
  parameter int CHAR_BITS      = 8,
  parameter int CYCLES_PER_BIT = 4,
  parameter int CLEAR_CYCLES   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  output logic                 tx_irq,
  output logic [NUM_LINES-1:0] ser_out,
  output logic                 dtr_n
);
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic                 clr, scan_en, tie, dtr_bit, data_wr, ready, accept;
  logic [NUM_LINES-1:0] en, busy, load;
  logic [LW-1:0]        cur_line;
  logic [CHAR_BITS-1:0] tx_char;

  txs_regs #(
    .NUM_LINES(NUM_LINES), .CHAR_BITS(CHAR_BITS), .CLEAR_CYCLES(CLEAR_CYCLES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ready(ready), .cur_line(cur_line), .clr(clr),
    .scan_en(scan_en), .tie(tie), .en(en), .dtr_bit(dtr_bit),
    .data_wr(data_wr), .tx_char(tx_char)
  );

  txs_scanner #(.NUM_LINES(NUM_LINES)) u_scan (
    .clk(clk), .rst_n(rst_n), .clr(clr), .scan_en(scan_en), .en(en),
    .busy(busy), .load(accept), .ready(ready), .cur_line(cur_line)
  );

  assign accept = data_wr && ready;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign load[i] = accept && (cur_line == LW'(i));
    txs_serializer #(
      .CHAR_BITS(CHAR_BITS), .CYCLES_PER_BIT(CYCLES_PER_BIT)
    ) u_ser (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(load[i]), .data(tx_char),
      .busy(busy[i]), .sout(ser_out[i])
    );
  end

  assign tx_irq = ready && tie;
  assign dtr_n  = ~dtr_bit;

  // R5: at most one serializer takes a character per write
  a_r5_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load));
  // R10: a clear leaves every line idle one cycle later
  a_r10_lines_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ser_out == '1));
  // R6: a data write without ready starts no frame
  a_r6_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ready) |-> (load == '0));
endmodule

// File: tb/tb_txs_mux.sv
module tb_txs_mux;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic        tx_irq, dtr_n;
  logic [3:0]  ser_out;

  int tests = 0, fails = 0, bad_stop = 0;
  bit done = 0;
  bit       rx_act [4];
  int       rx_c   [4];
  int       rx_n   [4];
  logic [7:0] rx_sh [4];
  logic [7:0] rx_last [4];

  always #2 clk = ~clk;

  txs_mux dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_irq(tx_irq),
    .ser_out(ser_out), .dtr_n(dtr_n));

  initial for (int i = 0; i < 4; i++) begin
    rx_act[i] = 0; rx_c[i] = 0; rx_n[i] = 0; rx_sh[i] = 0; rx_last[i] = 0;
  end

  // independent frame decoder per line, 4 cycles per bit
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rx_act[i]) begin
        rx_c[i]++;
        if (rx_c[i] >= 6 && rx_c[i] <= 34 && rx_c[i] % 4 == 2)
          rx_sh[i] = {ser_out[i], rx_sh[i][7:1]};
        if (rx_c[i] == 38) begin
          if (ser_out[i] !== 1'b1) bad_stop++;
          rx_last[i] = rx_sh[i];
          rx_n[i]++;
          rx_act[i] = 0;
        end
      end else if (rst_n && ser_out[i] === 1'b0) begin
        rx_act[i] = 1; rx_c[i] = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_ready(output bit ok, output int ln);
    logic [15:0] v;
    ok = 0; ln = -1;
    for (int k = 0; k < 300; k++) begin
      rd_reg(0, v);
      if (v[15]) begin ok = 1; ln = int'(v[9:8]); break; end
      @(negedge clk);
    end
  endtask

  task automatic do_clear();
    wr_reg(0, 16'h0010);
    repeat (17) @(negedge clk);
  endtask

  function automatic int next_en(input int mask, input int from);
    for (int k = 0; k < 4; k++)
      if (mask[(from + k) % 4]) return (from + k) % 4;
    return -1;
  endfunction

  initial begin
    logic [15:0] v;
    bit ok;
    int ln, p, exp_l, old_n, old_sum, sum;
    logic [7:0] ch;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_reg(0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd_reg(1, v); chk(v == 0, "R1 tctl", v, 0);
    chk(tx_irq == 0, "R1 irq", tx_irq, 0);
    chk(ser_out == 4'hF, "R1 ser_out", ser_out, 4'hF);
    chk(dtr_n == 1, "R1 dtr_n", dtr_n, 1);

    // R2 / R11 readback and DTR
    wr_reg(1, 16'hFFFF);
    rd_reg(1, v); chk(v == 16'h040F, "R2 tctl readback", v, 16'h040F);
    chk(dtr_n == 0, "R11 dtr asserted", dtr_n, 0);
    wr_reg(1, 16'h0005);
    chk(dtr_n == 1, "R11 dtr released", dtr_n, 1);
    wr_reg(1, 16'h040F);

    // R10 clear timing and effect
    wr_reg(0, 16'h0010);
    for (int k = 1; k <= 17; k++) begin
      rd_reg(0, v);
      chk(v[4] == (k <= 16), "R10 clear bit timing", v[4], (k <= 16));
      @(negedge clk);
    end
    rd_reg(1, v); chk(v == 0, "R10 tctl cleared", v, 0);
    chk(dtr_n == 1, "R10 dtr cleared", dtr_n, 1);

    // R3 scan disabled: no ready
    wr_reg(1, 16'h000F);
    wr_reg(0, 16'h4000);
    repeat (20) @(negedge clk);
    rd_reg(0, v); chk(v[15] == 0, "R3 no ready without scan", v[15], 0);
    chk(tx_irq == 0, "R9 irq low without ready", tx_irq, 0);

    // R9 interrupt needs both bits
    wr_reg(0, 16'h0020);
    wait_ready(ok, ln);
    chk(ok, "R3 ready with scan", ok, 1);
    chk(ln == 0, "R4 first line after clear", ln, 0);
    chk(tx_irq == 0, "R9 irq off with tie=0", tx_irq, 0);
    wr_reg(0, 16'h4020);
    chk(tx_irq == 1, "R9 irq on", tx_irq, 1);

    // R6 write without ready ignored
    wr_reg(0, 16'h0000);
    repeat (2) @(negedge clk);
    rd_reg(0, v); chk(v[15] == 0, "R3 ready drops with scan off", v[15], 0);
    old_sum = rx_n[0] + rx_n[1] + rx_n[2] + rx_n[3];
    wr_reg(2, 16'h0055);
    ok = 1;
    for (int k = 0; k < 60; k++) begin
      if (ser_out != 4'hF) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R6 lines stay idle", ok, 1);
    sum = rx_n[0] + rx_n[1] + rx_n[2] + rx_n[3];
    chk(sum == old_sum, "R6 no frame", sum, old_sum);

    // R4 / R5 sweep of every enable mask
    for (int mask = 1; mask < 16; mask++) begin
      do_clear();
      wr_reg(1, 16'(mask));
      wr_reg(0, 16'h4020);
      p = 0;
      for (int n = 0; n < 6; n++) begin
        exp_l = next_en(mask, p);
        wait_ready(ok, ln);
        chk(ok && ln == exp_l, "R4 round-robin line", ln, exp_l);
        chk(tx_irq == 1, "R9 irq with ready", tx_irq, 1);
        ch = 8'(mask * 13 + n * 37 + 1);
        old_n = rx_n[exp_l];
        old_sum = rx_n[0] + rx_n[1] + rx_n[2] + rx_n[3];
        wr_reg(2, {8'hA0, ch});
        rd_reg(0, v); chk(v[15] == 0, "R5 ready clears after write", v[15], 0);
        repeat (45) @(negedge clk);
        chk(rx_n[exp_l] == old_n + 1 && rx_last[exp_l] == ch,
            "R5 char on served line", rx_last[exp_l], ch);
        sum = rx_n[0] + rx_n[1] + rx_n[2] + rx_n[3];
        chk(sum == old_sum + 1, "R5 only one frame", sum, old_sum + 1);
        p = (exp_l + 1) % 4;
      end
    end

    // R7 busy line not re-offered
    do_clear();
    wr_reg(1, 16'h0001);
    wr_reg(0, 16'h0020);
    wait_ready(ok, ln);
    wr_reg(2, 16'h003C);
    ok = 1;
    for (int k = 0; k < 30; k++) begin
      rd_reg(0, v);
      if (v[15]) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R7 no offer while busy", ok, 1);
    wait_ready(ok, ln);
    chk(ok && ln == 0, "R7 offered again when idle", ln, 0);

    // R8 steering by masking; R2 masked line never served
    do_clear();
    wr_reg(1, 16'h000F);
    wr_reg(0, 16'h0020);
    wait_ready(ok, ln);
    chk(ln == 0, "R8 first offer", ln, 0);
    wr_reg(1, 16'h000E);
    repeat (3) @(negedge clk);
    wait_ready(ok, ln);
    chk(ok && ln == 1, "R8 dropped to line 1", ln, 1);
    wr_reg(1, 16'h000C);
    repeat (3) @(negedge clk);
    wait_ready(ok, ln);
    chk(ok && ln == 2, "R8 dropped to line 2", ln, 2);
    old_n = rx_n[0] + rx_n[1];
    wr_reg(2, 16'h00A5);
    repeat (45) @(negedge clk);
    chk(rx_last[2] == 8'hA5, "R8 char on line 2", rx_last[2], 8'hA5);
    chk(rx_n[0] + rx_n[1] == old_n, "R2 masked lines idle", rx_n[0] + rx_n[1], old_n);

    chk(bad_stop == 0, "R5 stop bits", bad_stop, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule